// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes replies coming back from audio codecs and stores them in a circular buffer in host memory. Each reply carries a 32-bit payload, a flag marking it as unsolicited and the 4-bit address of the codec that sent it. A reply becomes one 8-byte slot in the ring. The payload goes in the first 32-bit word. A descriptor word goes in the second: it holds the codec address and an unsolicited marker. Slots are written one word at a time through a simple memory write port that can apply backpressure.

Interrupts are grouped so that software is not woken for every reply. A reply counter is compared with a programmable threshold. An interrupt status bit is raised when the threshold is reached or when the command ring that feeds the codecs has drained. While the counter sits at the threshold, the command fetcher is told to pause. Clearing the status bit resets the counter and tells the fetcher to resume. A separate single-entry path catches the reply to an immediate command: while that path is marked busy, the reply bypasses the ring and lands in a holding register.

Top module: `resp_ring_engine`

## Requirements
- R1: After reset the write pointer, the reply counter, the interrupt status bit, the immediate busy flag and the immediate valid flag are all zero, `rsp_ready` is 1 and no memory write is requested.
- R2: The 8-bit write pointer is incremented by one, modulo 256, before each slot is written, so the first slot after reset is slot 1 and slot 255 is followed by slot 0.
- R3: A slot is written as two words: the payload at `ring_base + 8*ptr`, then the descriptor at `ring_base + 8*ptr + 4`, where ptr is the incremented pointer.
- R4: In the descriptor word, bits 3:0 hold the codec address, bit 4 is 1 for an unsolicited reply, and all other bits are zero.
- R5: While `ring_dma_en` is 0, a reply that is not taken by the immediate path is dropped: nothing is written to memory, and the pointer and counter do not change.
- R6: The counter is incremented each time a slot completes. If the new count equals `irq_threshold` and `ring_irq_en` is 1, `irq_sts` is set.
- R7: When a slot completes while `cmd_ring_empty` is 1, `irq_sts` is set if `ring_irq_en` is 1. While `ring_irq_en` is 0, `irq_sts` is never set.
- R8: A `sts_clear` pulse while `irq_sts` is 1 clears `irq_sts` and resets the counter to zero on the next edge. In the same cycle it drives `fetch_restart` high.
- R9: `fetch_allow` is 0 exactly while the counter equals `irq_threshold`.
- R10: A `wp_reset` pulse returns the write pointer to zero on the next edge.
- R11: An `imm_issue` pulse sets `imm_busy`. A reply accepted while `imm_busy` is 1 is stored in `imm_resp` with its codec address in `imm_cad`, clears `imm_busy`, sets `imm_valid`, and writes nothing to the ring. `imm_valid_clr` clears `imm_valid`.
- R12: `rsp_ready` is 1 only when no slot write is pending, so the next reply waits until both words of the previous slot are written. While `mem_wr_ready` is 0, the requested address and data are held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | A codec reply is presented |
| rsp_ready | output | 1 | The block can accept a reply this cycle |
| rsp_data | input | 32 | Reply payload |
| rsp_unsol | input | 1 | 1 for an unsolicited reply |
| rsp_cad | input | 4 | Address of the replying codec |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Byte address of the word being written |
| mem_wr_data | output | 32 | Word being written |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| ring_base | input | 32 | Byte base address of the ring (8-byte aligned) |
| ring_dma_en | input | 1 | Allow ring writes |
| ring_irq_en | input | 1 | Allow the interrupt status bit to be set |
| irq_threshold | input | 8 | Counter value that raises the status bit |
| wp_reset | input | 1 | Pulse: clear the write pointer |
| cmd_ring_empty | input | 1 | The command ring has no pending commands |
| sts_clear | input | 1 | Pulse: write-one-to-clear of the status bit |
| imm_issue | input | 1 | Pulse: an immediate command was sent |
| imm_valid_clr | input | 1 | Pulse: clear the immediate valid flag |
| wp_out | output | 8 | Current write pointer |
| resp_count | output | 8 | Replies counted since the last clear |
| irq_sts | output | 1 | Interrupt status bit |
| fetch_allow | output | 1 | Command fetching may proceed |
| fetch_restart | output | 1 | Command fetching should resume |
| imm_resp | output | 32 | Payload of the last immediate reply |
| imm_busy | output | 1 | An immediate reply is awaited |
| imm_valid | output | 1 | `imm_resp` holds a new reply |
| imm_cad | output | 4 | Codec address of the immediate reply |

## Verification
The bench steps the pointer through its wrap from slot 255 to slot 0. A design that used the old pointer, or that wrapped at the wrong width, would write to the wrong address there. The bench brings the counter exactly onto the threshold and checks both the status bit and the fetch gate: an off-by-one compare would raise the bit one reply early or one reply late. It also stalls memory in the middle of a slot and sends replies with DMA disabled and with the immediate path busy. A design that got these wrong would let its address drift under the stall, would advance the pointer for a dropped reply, or would send an immediate reply into the ring.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WORD0 = 2'd1,
    PH_WORD1 = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/resp_imm_slot.sv
module resp_imm_slot #(
  parameter int DATA_W = 32,
  parameter int CAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] take_data,
  input  logic [CAD_W-1:0]  take_cad,
  input  logic              issue,
  input  logic              valid_clr,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] resp,
  output logic [CAD_W-1:0]  cad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      resp  <= '0;
      cad   <= '0;
    end else begin
      if (take) begin
        resp <= take_data;
        cad  <= take_cad;
      end
      // a new issue in the same cycle wins over the completion
      if (issue)     busy <= 1'b1;
      else if (take) busy <= 1'b0;
      if (take)           valid <= 1'b1;
      else if (valid_clr) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_ring_wseq.sv
module resp_ring_wseq
  import resp_ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int CAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_unsol,
  input  logic [CAD_W-1:0]  rsp_cad,
  input  logic              imm_busy,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              wp_reset,
  input  logic              mem_wr_ready,
  output logic              rsp_ready,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [PTR_W-1:0]  wp,
  output logic              ev_accept_ring,
  output logic              ev_drop,
  output logic              ev_imm_take,
  output logic              ev_word0_done,
  output logic              ev_entry_done
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);
  localparam int UNSOL_BIT   = CAD_W;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [PTR_W-1:0]  ptr);
    logic [ADDR_W-1:0] ofs;
    ofs = ADDR_W'(ptr) << ENTRY_SHIFT;
    return base + ofs;
  endfunction

  function automatic logic [DATA_W-1:0] desc_word(input logic             unsol,
                                                  input logic [CAD_W-1:0] c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CAD_W-1:0] = c;
    w[UNSOL_BIT] = unsol;
    return w;
  endfunction

  wr_phase_e         phase;
  logic [DATA_W-1:0] word0_q, word1_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  wp_next;
  logic              accept;

  assign rsp_ready      = (phase == PH_IDLE);
  assign accept         = rsp_valid && rsp_ready;
  assign ev_imm_take    = accept && imm_busy;
  assign ev_drop        = accept && !imm_busy && !dma_en;
  assign ev_accept_ring = accept && !imm_busy && dma_en;
  assign wp_next        = wp + PTR_W'(1);
  assign ev_word0_done  = (phase == PH_WORD0) && mem_wr_ready;
  assign ev_entry_done  = (phase == PH_WORD1) && mem_wr_ready;

  assign mem_wr_en   = (phase != PH_IDLE);
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = (phase == PH_WORD1) ? word1_q : word0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      wp      <= '0;
      addr_q  <= '0;
      word0_q <= '0;
      word1_q <= '0;
    end else begin
      if (wp_reset)            wp <= '0;
      else if (ev_accept_ring) wp <= wp_next;
      case (phase)
        PH_IDLE: begin
          if (ev_accept_ring) begin
            addr_q  <= slot_addr(ring_base, wp_next);
            word0_q <= rsp_data;
            word1_q <= desc_word(rsp_unsol, rsp_cad);
            phase   <= PH_WORD0;
          end
        end
        PH_WORD0: begin
          if (mem_wr_ready) begin
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            phase  <= PH_WORD1;
          end
        end
        PH_WORD1: begin
          if (mem_wr_ready) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resp_coalesce.sv
module resp_coalesce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_done,
  input  logic             irq_en,
  input  logic             cmd_empty,
  input  logic [CNT_W-1:0] threshold,
  input  logic             sts_clear,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             fetch_allow,
  output logic             fetch_restart
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic             clr,
                                                  input logic             inc);
    logic [CNT_W-1:0] b;
    b = clr ? '0 : cur;
    return b + CNT_W'(inc);
  endfunction

  logic             clear_ok;
  logic [CNT_W-1:0] count_nx;
  logic             raise;

  assign clear_ok      = sts_clear && irq;
  assign count_nx      = next_count(count, clear_ok, entry_done);
  assign raise         = entry_done && irq_en && ((count_nx == threshold) || cmd_empty);
  assign fetch_allow   = (count != threshold);
  assign fetch_restart = clear_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      count <= count_nx;
      irq   <= raise || (irq && !clear_ok);
    end
  end
endmodule

// File: rtl/resp_ring_engine.sv
module resp_ring_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8,
  parameter int CAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_unsol,
  input  logic [CAD_W-1:0]  rsp_cad,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              ring_dma_en,
  input  logic              ring_irq_en,
  input  logic [CNT_W-1:0]  irq_threshold,
  input  logic              wp_reset,
  input  logic              cmd_ring_empty,
  input  logic              sts_clear,
  input  logic              imm_issue,
  input  logic              imm_valid_clr,
  output logic [PTR_W-1:0]  wp_out,
  output logic [CNT_W-1:0]  resp_count,
  output logic              irq_sts,
  output logic              fetch_allow,
  output logic              fetch_restart,
  output logic [DATA_W-1:0] imm_resp,
  output logic              imm_busy,
  output logic              imm_valid,
  output logic [CAD_W-1:0]  imm_cad
);
  logic ev_accept_ring, ev_drop, ev_imm_take, ev_word0_done, ev_entry_done;

  resp_ring_wseq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CAD_W(CAD_W)
  ) u_wseq (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_unsol(rsp_unsol), .rsp_cad(rsp_cad),
    .imm_busy(imm_busy), .dma_en(ring_dma_en), .ring_base(ring_base),
    .wp_reset(wp_reset), .mem_wr_ready(mem_wr_ready),
    .rsp_ready(rsp_ready), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .wp(wp_out),
    .ev_accept_ring(ev_accept_ring), .ev_drop(ev_drop), .ev_imm_take(ev_imm_take),
    .ev_word0_done(ev_word0_done), .ev_entry_done(ev_entry_done)
  );

  resp_coalesce #(.CNT_W(CNT_W)) u_coalesce (
    .clk(clk), .rst_n(rst_n),
    .entry_done(ev_entry_done), .irq_en(ring_irq_en), .cmd_empty(cmd_ring_empty),
    .threshold(irq_threshold), .sts_clear(sts_clear),
    .count(resp_count), .irq(irq_sts), .fetch_allow(fetch_allow),
    .fetch_restart(fetch_restart)
  );

  resp_imm_slot #(.DATA_W(DATA_W), .CAD_W(CAD_W)) u_imm (
    .clk(clk), .rst_n(rst_n),
    .take(ev_imm_take), .take_data(rsp_data), .take_cad(rsp_cad),
    .issue(imm_issue), .valid_clr(imm_valid_clr),
    .busy(imm_busy), .valid(imm_valid), .resp(imm_resp), .cad(imm_cad)
  );
endmodule

// File: rtl/resp_ring_chk.sv
module resp_ring_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8,
  parameter int CAD_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CAD_W-1:0]  rsp_cad,
  input logic              mem_wr_en,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              ring_irq_en,
  input logic              wp_reset,
  input logic              sts_clear,
  input logic              imm_issue,
  input logic [PTR_W-1:0]  wp_out,
  input logic [CNT_W-1:0]  resp_count,
  input logic              irq_sts,
  input logic [DATA_W-1:0] imm_resp,
  input logic              imm_busy,
  input logic              imm_valid,
  input logic [CAD_W-1:0]  imm_cad,
  input logic              ev_accept_ring,
  input logic              ev_drop,
  input logic              ev_imm_take,
  input logic              ev_word0_done,
  input logic              ev_entry_done
);
  // R12
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !rsp_ready);
  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en && !mem_wr_ready |=> mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data));
  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word0_done |=> mem_wr_en && (mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(DATA_W/8)));
  // R2
  wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_ring && !wp_reset |=> wp_out == $past(wp_out) + PTR_W'(1));
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop && !wp_reset |=> wp_out == $past(wp_out) && !mem_wr_en);
  // R10
  wp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_reset |=> wp_out == '0);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_done && !(sts_clear && irq_sts) |=> resp_count == $past(resp_count) + CNT_W'(1));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts) |-> $past(ring_irq_en));
  // R8
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clear && irq_sts && !ev_entry_done |=> !irq_sts && resp_count == '0);
  // R11
  imm_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_imm_take && !imm_issue |=> imm_valid && !imm_busy && imm_cad == $past(rsp_cad)
      && imm_resp == $past(rsp_data));
endmodule

bind resp_ring_engine resp_ring_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .CAD_W(CAD_W)
) i_resp_ring_chk (
  .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_cad(rsp_cad),
  .mem_wr_en(mem_wr_en), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .ring_irq_en(ring_irq_en), .wp_reset(wp_reset),
  .sts_clear(sts_clear), .imm_issue(imm_issue), .wp_out(wp_out), .resp_count(resp_count),
  .irq_sts(irq_sts), .imm_resp(imm_resp), .imm_busy(imm_busy), .imm_valid(imm_valid),
  .imm_cad(imm_cad), .ev_accept_ring(ev_accept_ring), .ev_drop(ev_drop),
  .ev_imm_take(ev_imm_take), .ev_word0_done(ev_word0_done), .ev_entry_done(ev_entry_done)
);

// File: tb/test_resp_ring_engine.sv
module test_resp_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0, rsp_unsol = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [3:0]  rsp_cad = '0;
  logic        rsp_ready, mem_wr_en, mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [31:0] ring_base = BASE;
  logic        ring_dma_en = 1'b1, ring_irq_en = 1'b0;
  logic [7:0]  irq_threshold = 8'd16;
  logic        wp_reset = 1'b0, cmd_ring_empty = 1'b0, sts_clear = 1'b0;
  logic        imm_issue = 1'b0, imm_valid_clr = 1'b0;
  logic [7:0]  wp_out, resp_count;
  logic        irq_sts, fetch_allow, fetch_restart, imm_busy, imm_valid;
  logic [31:0] imm_resp;
  logic [3:0]  imm_cad;

  int errors = 0, checks = 0, log_n = 0;
  bit done = 1'b0;
  logic [31:0] log_addr [0:1023];
  logic [31:0] log_data [0:1023];
  logic [7:0]  exp_wp = 8'd0, exp_cnt = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_ring_engine i_resp_ring_engine (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_unsol(rsp_unsol), .rsp_cad(rsp_cad),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready), .ring_base(ring_base), .ring_dma_en(ring_dma_en),
    .ring_irq_en(ring_irq_en), .irq_threshold(irq_threshold), .wp_reset(wp_reset),
    .cmd_ring_empty(cmd_ring_empty), .sts_clear(sts_clear), .imm_issue(imm_issue),
    .imm_valid_clr(imm_valid_clr), .wp_out(wp_out), .resp_count(resp_count),
    .irq_sts(irq_sts), .fetch_allow(fetch_allow), .fetch_restart(fetch_restart),
    .imm_resp(imm_resp), .imm_busy(imm_busy), .imm_valid(imm_valid), .imm_cad(imm_cad)
  );

  // memory model: record each accepted write just ahead of the edge that takes it
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (mem_wr_en && mem_wr_ready && log_n < 1024) begin
      log_addr[log_n] = mem_wr_addr;
      log_data[log_n] = mem_wr_data;
      log_n++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] w, input logic u, input logic [3:0] c);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = w; rsp_unsol = u; rsp_cad = c;
    @(negedge clk);
    rsp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // send a reply that must land in the ring; optionally check the slot
  task automatic ring_entry(input logic [31:0] w, input logic u, input logic [3:0] c,
                            input bit check);
    int n0;
    logic [31:0] a;
    n0 = log_n;
    send(w, u, c);
    exp_wp  = exp_wp + 8'd1;
    exp_cnt = exp_cnt + 8'd1;
    a = ring_base + {21'd0, exp_wp, 3'd0};
    if (check) begin
      chk("R3 two words written", 64'(log_n - n0), 64'd2);
      chk("R3 payload address", 64'(log_addr[n0]), 64'(a));
      chk("R3 payload word", 64'(log_data[n0]), 64'(w));
      chk("R3 descriptor address", 64'(log_addr[n0+1]), 64'(a + 32'd4));
      chk("R4 descriptor word", 64'(log_data[n0+1]), {59'd0, u, c});
      chk("R2 write pointer", 64'(wp_out), 64'(exp_wp));
      chk("R6 counter", 64'(resp_count), 64'(exp_cnt));
    end
  endtask

  task automatic clear_status();
    @(negedge clk);
    sts_clear = 1'b1;
    #1;
    chk("R8 fetch_restart pulse", 64'(fetch_restart), 64'd1);
    @(negedge clk);
    sts_clear = 1'b0;
    exp_cnt = 8'd0;
    chk("R8 status cleared", 64'(irq_sts), 64'd0);
    chk("R8 counter zeroed", 64'(resp_count), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 wp", 64'(wp_out), 64'd0);
    chk("R1 count", 64'(resp_count), 64'd0);
    chk("R1 irq", 64'(irq_sts), 64'd0);
    chk("R1 imm busy", 64'(imm_busy), 64'd0);
    chk("R1 imm valid", 64'(imm_valid), 64'd0);
    chk("R1 ready", 64'(rsp_ready), 64'd1);
    chk("R1 no write", 64'(mem_wr_en), 64'd0);
  endtask

  task automatic t_basic();
    ring_entry(32'hCAFE_0001, 1'b0, 4'h3, 1'b1);
    ring_entry(32'h1234_5678, 1'b1, 4'hA, 1'b1);
    chk("R7 no irq while disabled", 64'(irq_sts), 64'd0);
  endtask

  task automatic t_threshold();
    ring_irq_en = 1'b1; cmd_ring_empty = 1'b0;
    irq_threshold = exp_cnt + 8'd2;
    ring_entry(32'hAAAA_0001, 1'b0, 4'h1, 1'b1);
    chk("R6 below threshold no irq", 64'(irq_sts), 64'd0);
    chk("R9 fetch allowed below threshold", 64'(fetch_allow), 64'd1);
    ring_entry(32'hAAAA_0002, 1'b0, 4'h1, 1'b1);
    chk("R6 irq at threshold", 64'(irq_sts), 64'd1);
    chk("R9 fetch paused at threshold", 64'(fetch_allow), 64'd0);
    clear_status();
    chk("R9 fetch resumes after clear", 64'(fetch_allow), 64'd1);
  endtask

  task automatic t_drained();
    irq_threshold = 8'd50; cmd_ring_empty = 1'b1; ring_irq_en = 1'b1;
    ring_entry(32'hBBBB_0001, 1'b1, 4'h2, 1'b1);
    chk("R7 irq on drained command ring", 64'(irq_sts), 64'd1);
    clear_status();
    ring_irq_en = 1'b0;
    ring_entry(32'hBBBB_0002, 1'b0, 4'h2, 1'b1);
    chk("R7 no irq with enable clear", 64'(irq_sts), 64'd0);
    cmd_ring_empty = 1'b0;
  endtask

  task automatic t_drop();
    int n0;
    n0 = log_n;
    ring_dma_en = 1'b0;
    send(32'hDEAD_0000, 1'b0, 4'h4);
    chk("R5 no memory write", 64'(log_n - n0), 64'd0);
    chk("R5 wp unchanged", 64'(wp_out), 64'(exp_wp));
    chk("R5 count unchanged", 64'(resp_count), 64'(exp_cnt));
    ring_dma_en = 1'b1;
  endtask

  task automatic t_immediate();
    int n0;
    @(negedge clk); imm_issue = 1'b1;
    @(negedge clk); imm_issue = 1'b0;
    chk("R11 busy after issue", 64'(imm_busy), 64'd1);
    n0 = log_n;
    send(32'hBEEF_0042, 1'b0, 4'h5);
    chk("R11 imm payload", 64'(imm_resp), 64'h0000_0000_BEEF_0042);
    chk("R11 valid set", 64'(imm_valid), 64'd1);
    chk("R11 busy cleared", 64'(imm_busy), 64'd0);
    chk("R11 cad", 64'(imm_cad), 64'd5);
    chk("R11 ring untouched", 64'(log_n - n0), 64'd0);
    chk("R11 wp untouched", 64'(wp_out), 64'(exp_wp));
    @(negedge clk); imm_valid_clr = 1'b1;
    @(negedge clk); imm_valid_clr = 1'b0;
    chk("R11 valid cleared", 64'(imm_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] a0, d0;
    int n0;
    n0 = log_n;
    mem_wr_ready = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 32'h5150_0077; rsp_unsol = 1'b1; rsp_cad = 4'h7;
    @(negedge clk);
    rsp_valid = 1'b0;
    exp_wp = exp_wp + 8'd1; exp_cnt = exp_cnt + 8'd1;
    a0 = mem_wr_addr; d0 = mem_wr_data;
    chk("R3 stalled address", 64'(a0), 64'(ring_base + {21'd0, exp_wp, 3'd0}));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 request held", 64'(mem_wr_en), 64'd1);
      chk("R12 address held", 64'(mem_wr_addr), 64'(a0));
      chk("R12 data held", 64'(mem_wr_data), 64'(d0));
      chk("R12 not ready while pending", 64'(rsp_ready), 64'd0);
    end
    mem_wr_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 both words after stall", 64'(log_n - n0), 64'd2);
    chk("R4 descriptor after stall", 64'(log_data[n0+1]), 64'h17);
    chk("R12 ready again", 64'(rsp_ready), 64'd1);
  endtask

  task automatic t_wrap();
    @(negedge clk); wp_reset = 1'b1;
    @(negedge clk); wp_reset = 1'b0;
    exp_wp = 8'd0;
    chk("R10 wp cleared", 64'(wp_out), 64'd0);
    for (int i = 0; i < 255; i++) ring_entry(32'h7000_0000 + 32'(i), 1'b0, 4'h0, 1'b0);
    chk("R2 wp at 255", 64'(wp_out), 64'd255);
    chk("R3 slot 255 address", 64'(log_addr[log_n-2]), 64'(BASE + 32'h7F8));
    ring_entry(32'h7FFF_FFFF, 1'b1, 4'hF, 1'b1);
    chk("R2 wrap to slot 0", 64'(log_addr[log_n-2]), 64'(BASE));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_threshold();
    t_drained();
    t_drop();
    t_immediate();
    t_backpressure();
    t_wrap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule